// File: doc/BRIEF.md
# Biphase Subframe Preamble Classifier

This block watches a stream of single-cycle edge pulses taken from a biphase-mark line. Each pulse marks a transition on the line. Call the shortest pulse spacing t; it is half a bit cell. Valid data never leaves more than 2t between pulses. Every subframe opens with a synchronisation pattern whose first interval is 3t long. The block uses that gap to spot the start of a subframe. It then decides which of the three pattern kinds arrived: block start (B), left channel (M) or right channel (W).

The block keeps a restartable silence timer in system clocks. If no pulse arrives for about 2.5t, the timer fires and the preamble-active output rises. This happens before the opening long interval has ended. The pulse that closes the long interval starts a second timer and a pulse tally. About 2.5t later the block decides the kind:
- two or more pulses in that window mean a block start;
- no pulse means another 3t interval, so a left-channel pattern;
- one pulse means a right-channel pattern.

The left-channel and block-start flags are loaded at that decision and hold until the next one. Preamble-active falls half a t before the first data pulse that follows the pattern. A bit decoder uses it to close the subframe word, and a word assembler samples the flags. The nominal t is a parameter in clock cycles, and every threshold is derived from it.

Top module: `preamble_classifier`

## Requirements
- R1: While reset is asserted and on the first cycle after its release, `pre_active_o`, `left_o` and `blk_o` are 0.
- R2: A pulse stream whose spacing never exceeds 2t (t = `T_CYC` cycles) never raises `pre_active_o`.
- R3: When `pre_active_o` is low and no pulse arrives, `pre_active_o` rises exactly TO = floor(5*T_CYC/2) cycles after the last pulse was sampled.
- R4: `pre_active_o` falls exactly END = floor(9*T_CYC/2) cycles after the first pulse that arrives after it rose.
- R5: Pulse intervals 3t,1t,1t,3t (block-start pattern) set `left_o`=1 and `blk_o`=1.
- R6: Pulse intervals 3t,3t,1t,1t (left pattern) set `left_o`=1 and `blk_o`=0.
- R7: Pulse intervals 3t,2t,1t,2t (right pattern) set `left_o`=0 and `blk_o`=0.
- R8: `left_o` and `blk_o` change only while `pre_active_o` is high. They hold their values through the data between patterns.
- R9: If no pulse arrives within LOST = floor(9*T_CYC/2) cycles of the last pulse after `pre_active_o` rose, `pre_active_o` falls at that count and the flags keep their values. A silence of any length raises `pre_active_o` only once.
- R10: `blk_o` is never 1 while `left_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pulse_i | input | 1 | One-cycle pulse per line transition, already synchronised to clk_i |
| pre_active_o | output | 1 | High from the timeout until just before the first data pulse after the pattern |
| left_o | output | 1 | 1 when the last pattern was block-start or left, 0 when it was right |
| blk_o | output | 1 | 1 when the last pattern was block-start |

## Verification
The assertions assume that `pulse_i` comes from a synchronised edge detector, so it is a single-cycle strobe in the clock domain. They also assume the line timing is near nominal, so spacings are integer multiples of `T_CYC`. They assume that, after a detected pattern, the next pulse does not arrive before `pre_active_o` has fallen. The directed stimulus builds every interval as an exact multiple of `T_CYC` cycles. It drives each pulse high for one cycle and starts with a data bit right after each 8t pattern. The only stretches that break the data spacing are the deliberate silences in the start-up and lost-signal scenarios.

// File: rtl/preamble_classifier_pkg.sv
`timescale 1ns/1ps
package preamble_classifier_pkg;

  typedef enum logic [1:0] {
    ST_HUNT = 2'd0,  // watching data spacing
    ST_LONG = 2'd1,  // timeout fired, waiting for end of opening gap
    ST_MEAS = 2'd2,  // counting pulses in the decision window
    ST_TAIL = 2'd3   // decided, waiting for end of pattern
  } pre_state_e;

  typedef enum logic [1:0] {
    KIND_BLK   = 2'd0,
    KIND_LEFT  = 2'd1,
    KIND_RIGHT = 2'd2
  } pre_kind_e;

  typedef struct packed {
    logic left;
    logic blk;
  } pre_flags_t;

  function automatic pre_flags_t kind_to_flags(pre_kind_e k);
    pre_flags_t f;
    unique case (k)
      KIND_BLK:   f = '{left: 1'b1, blk: 1'b1};
      KIND_LEFT:  f = '{left: 1'b1, blk: 1'b0};
      default:    f = '{left: 1'b0, blk: 1'b0};
    endcase
    return f;
  endfunction

endpackage

// File: rtl/pre_gap_timer.sv
`timescale 1ns/1ps
// Cycles since the last pulse, saturating at SAT.
module pre_gap_timer #(
  parameter int CW  = 8,
  parameter int SAT = 100
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pulse_i,
  output logic [CW-1:0] gap_o
);
  localparam logic [CW-1:0] SAT_V = CW'(SAT);

  logic [CW-1:0] gap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             gap_q <= '0;
    else if (pulse_i)        gap_q <= '0;
    else if (gap_q != SAT_V) gap_q <= gap_q + 1'b1;
  end

  assign gap_o = gap_q;
endmodule

// File: rtl/pre_span_timer.sv
`timescale 1ns/1ps
// Elapsed cycles since clr_i; holds at all-ones.
module pre_span_timer #(
  parameter int CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  output logic [CW-1:0] span_o
);
  logic [CW-1:0] span_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            span_q <= '0;
    else if (clr_i)         span_q <= '0;
    else if (~&span_q)      span_q <= span_q + 1'b1;
  end

  assign span_o = span_q;
endmodule

// File: rtl/pre_pulse_tally.sv
`timescale 1ns/1ps
// Saturating pulse count; tally_next_o includes a pulse in the current cycle.
module pre_pulse_tally #(
  parameter int TW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          inc_i,
  output logic [TW-1:0] tally_next_o
);
  logic [TW-1:0] tally_q;
  logic [TW-1:0] tally_d;

  always_comb begin
    tally_d = tally_q;
    if (inc_i && !(&tally_q)) tally_d = tally_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     tally_q <= '0;
    else if (clr_i)  tally_q <= '0;
    else             tally_q <= tally_d;
  end

  assign tally_next_o = tally_d;
endmodule

// File: rtl/pre_kind_decode.sv
`timescale 1ns/1ps
module pre_kind_decode
  import preamble_classifier_pkg::*;
#(
  parameter int TW = 2
) (
  input  logic [TW-1:0] tally_i,
  output pre_flags_t    flags_o
);
  pre_kind_e kind;

  always_comb begin
    if (tally_i >= TW'(2))      kind = KIND_BLK;    // two short spacings
    else if (tally_i == '0)     kind = KIND_LEFT;   // second long gap
    else                        kind = KIND_RIGHT;  // single 2t spacing
    flags_o = kind_to_flags(kind);
  end
endmodule

// File: rtl/preamble_classifier.sv
`timescale 1ns/1ps
module preamble_classifier
  import preamble_classifier_pkg::*;
#(
  parameter int T_CYC = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pulse_i,
  output logic pre_active_o,
  output logic left_o,
  output logic blk_o
);
  localparam int TO_CYC   = (5 * T_CYC) / 2;
  localparam int WIN_CYC  = (5 * T_CYC) / 2;
  localparam int END_CYC  = (9 * T_CYC) / 2;
  localparam int LOST_CYC = (9 * T_CYC) / 2;
  localparam int CW       = $clog2(LOST_CYC + END_CYC + 2);
  localparam int TW       = 2;

  localparam logic [CW-1:0] TO_M1   = CW'(TO_CYC - 1);
  localparam logic [CW-1:0] WIN_M1  = CW'(WIN_CYC - 1);
  localparam logic [CW-1:0] END_M1  = CW'(END_CYC - 1);
  localparam logic [CW-1:0] LOST_M1 = CW'(LOST_CYC - 1);

  if (T_CYC < 4) begin : g_bad_t
    initial $error("T_CYC must be at least 4");
  end

  pre_state_e    st_q, st_d;
  logic [CW-1:0] gap;
  logic [CW-1:0] span;
  logic [TW-1:0] tally_next;
  logic          meas_start;
  pre_flags_t    dec_flags;
  pre_flags_t    flags_q;
  logic          decide;

  pre_gap_timer #(.CW(CW), .SAT(LOST_CYC)) u_gap (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pulse_i (pulse_i),
    .gap_o   (gap)
  );

  pre_span_timer #(.CW(CW)) u_span (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (meas_start),
    .span_o (span)
  );

  pre_pulse_tally #(.TW(TW)) u_tally (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .clr_i        (meas_start),
    .inc_i        (pulse_i && (st_q == ST_MEAS)),
    .tally_next_o (tally_next)
  );

  pre_kind_decode #(.TW(TW)) u_dec (
    .tally_i (tally_next),
    .flags_o (dec_flags)
  );

  assign meas_start = (st_q == ST_LONG) && pulse_i;
  assign decide     = (st_q == ST_MEAS) && (span == WIN_M1);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_HUNT: if (!pulse_i && gap == TO_M1)   st_d = ST_LONG;
      ST_LONG: begin
        if (pulse_i)                           st_d = ST_MEAS;
        else if (gap == LOST_M1)               st_d = ST_HUNT;
      end
      ST_MEAS: if (span == WIN_M1)             st_d = ST_TAIL;
      ST_TAIL: if (span == END_M1)             st_d = ST_HUNT;
      default:                                 st_d = ST_HUNT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_HUNT;
    else         st_q <= st_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flags_q <= '0;
    else if (decide) flags_q <= dec_flags;
  end

  assign pre_active_o = (st_q != ST_HUNT);
  assign left_o       = flags_q.left;
  assign blk_o        = flags_q.blk;
endmodule

// File: rtl/preamble_classifier_chk.sv
`timescale 1ns/1ps
module preamble_classifier_chk #(
  parameter int T_CYC = 8
) (
  input logic clk_i,
  input logic rst_ni,
  input logic pulse_i,
  input logic pre_active_o,
  input logic left_o,
  input logic blk_o
);
  localparam int TO_CYC   = (5 * T_CYC) / 2;
  localparam int END_CYC  = (9 * T_CYC) / 2;
  localparam int LOST_CYC = (9 * T_CYC) / 2;
  localparam int RUN_MAX  = LOST_CYC - TO_CYC + END_CYC;

  int unsigned quiet_q;
  int unsigned run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     quiet_q <= 0;
    else if (pulse_i)                quiet_q <= 0;
    else if (quiet_q < 100000)       quiet_q <= quiet_q + 1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           run_q <= 0;
    else if (pre_active_o) run_q <= run_q + 1;
    else                   run_q <= 0;
  end

  // R3 / R2: rising edge only after exactly TO quiet cycles
  a_r3_rise_after_timeout: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pre_active_o) |-> quiet_q == TO_CYC);

  // R8
  a_r8_flags_only_when_active: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(left_o) || !$stable(blk_o)) |-> pre_active_o);

  // R10
  a_r10_blk_implies_left: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blk_o |-> left_o);

  // R4 / R9: active window is bounded
  a_r9_active_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_active_o |-> run_q <= RUN_MAX);

  // R1
  a_r1_idle_after_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> !pre_active_o && !left_o && !blk_o);
endmodule

bind preamble_classifier preamble_classifier_chk #(.T_CYC(T_CYC)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .pulse_i      (pulse_i),
  .pre_active_o (pre_active_o),
  .left_o       (left_o),
  .blk_o        (blk_o)
);

// File: tb/sim_preamble_classifier.sv
`timescale 1ns/1ps
module sim_preamble_classifier;
  localparam int T    = 8;
  localparam int TO   = (5 * T) / 2;
  localparam int ENDC = (9 * T) / 2;
  localparam int LOST = (9 * T) / 2;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic pulse_i = 1'b0;
  logic pre_active_o, left_o, blk_o;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  preamble_classifier #(.T_CYC(T)) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .pulse_i(pulse_i),
    .pre_active_o(pre_active_o), .left_o(left_o), .blk_o(blk_o)
  );

  // monitor at negedge
  int ncyc = 0, last_p = 0, first_p = 0;
  int rise_cnt = 0, rise_gap = 0, fall_first = 0, fall_last = 0;
  bit want_first = 1'b0, act_prev = 1'b0;

  always @(negedge clk_i) begin
    ncyc++;
    if (pulse_i) begin
      last_p = ncyc;
      if (want_first) begin first_p = ncyc; want_first = 1'b0; end
    end
    if (pre_active_o && !act_prev) begin
      rise_cnt++; rise_gap = ncyc - last_p; want_first = 1'b1;
    end
    if (!pre_active_o && act_prev) begin
      fall_first = ncyc - first_p; fall_last = ncyc - last_p;
    end
    act_prev = pre_active_o;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic gap_after(input int n_t);
    for (int k = 0; k < n_t * T; k++) begin
      @(negedge clk_i); #1 pulse_i = (k == n_t * T - 1);
    end
  endtask

  task automatic go_quiet(input int cyc);
    for (int k = 0; k < cyc; k++) begin
      @(negedge clk_i); #1 pulse_i = 1'b0;
    end
  endtask

  task automatic send_bits(input logic [27:0] d);
    for (int i = 0; i < 28; i++) begin
      if (d[i]) begin gap_after(1); gap_after(1); end
      else gap_after(2);
    end
  endtask

  task automatic send_pre(input int a, input int b, input int c, input int d);
    gap_after(a); gap_after(b); gap_after(c); gap_after(d);
  endtask

  task automatic frame_check(input string tag, input int a, input int b, input int c,
                             input int d, input int exp_left, input int exp_blk);
    int r0;
    r0 = rise_cnt;
    send_pre(a, b, c, d);
    chk({tag, " R3 one rise"}, rise_cnt - r0, 1);
    chk({tag, " R3 rise gap"}, rise_gap, TO);
    chk({tag, " R4 fall after first pulse"}, fall_first, ENDC);
    chk({tag, " R4 low at first data pulse"}, int'(pre_active_o), 0);
    chk({tag, " left"}, int'(left_o), exp_left);
    chk({tag, " blk"}, int'(blk_o), exp_blk);
    send_bits(28'h5A3_C96F);
    chk({tag, " R8 left held"}, int'(left_o), exp_left);
    chk({tag, " R8 blk held"}, int'(blk_o), exp_blk);
  endtask

  task automatic t_reset();
    chk("R1 active in reset", int'(pre_active_o), 0);
    chk("R1 left in reset", int'(left_o), 0);
    chk("R1 blk in reset", int'(blk_o), 0);
    @(negedge clk_i); rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 active after release", int'(pre_active_o), 0);
    chk("R1 flags after release", int'({left_o, blk_o}), 0);
  endtask

  task automatic t_data_only();
    int r0;
    gap_after(1);
    r0 = rise_cnt;
    send_bits(28'h000_0000);
    send_bits(28'hFFF_FFFF);
    send_bits(28'h9C3_A517);
    chk("R2 no rise on data", rise_cnt - r0, 0);
    chk("R2 active low", int'(pre_active_o), 0);
  endtask

  task automatic t_blk();   frame_check("R5 block", 3, 1, 1, 3, 1, 1); endtask
  task automatic t_left();  frame_check("R6 left",  3, 3, 1, 1, 1, 0); endtask
  task automatic t_right(); frame_check("R7 right", 3, 2, 1, 2, 0, 0); endtask

  task automatic t_sequence();
    frame_check("R5 seq block", 3, 1, 1, 3, 1, 1);
    frame_check("R7 seq right", 3, 2, 1, 2, 0, 0);
    frame_check("R6 seq left",  3, 3, 1, 1, 1, 0);
    frame_check("R7 seq right2", 3, 2, 1, 2, 0, 0);
    frame_check("R5 seq block2", 3, 1, 1, 3, 1, 1);
  endtask

  task automatic t_lost();
    int r0;
    r0 = rise_cnt;
    go_quiet(200);
    chk("R9 single rise in silence", rise_cnt - r0, 1);
    chk("R9 fall after lost count", fall_last, LOST);
    chk("R9 active low", int'(pre_active_o), 0);
    chk("R9 left kept", int'(left_o), 1);
    chk("R9 blk kept", int'(blk_o), 1);
    gap_after(1);
    send_bits(28'h123_4567);
    frame_check("R6 after lost", 3, 3, 1, 1, 1, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    go_quiet(60);   // start-up silence fires once and is abandoned
    t_data_only();
    t_blk();
    t_left();
    t_right();
    t_sequence();
    t_lost();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule